// File: doc/BRIEF.md
# Configuration-Space Target Sequencer

This block is a 32-bit parallel-bus target that answers only configuration reads and writes. A transaction is claimed when the chip-select input is high in the address phase. The block then reads or writes a small bank of 32-bit registers through the multiplexed address/data lines. It samples the bus inputs on the rising clock edge, claims the access with an active-low device-select, and paces each data phase with an active-low target-ready. It can also end a burst early by asserting an active-low stop request.

The first clock of a transaction, where the cycle-frame input is first seen low, is the address phase. Every clock after it belongs to a data phase. On those data-phase clocks the 4-bit command lines carry active-low byte enables. A data phase completes only on an edge where the initiator-ready and target-ready lines are both low. All driven outputs come from registers. An output-enable bit stands in for each tri-state group.

Top module: `cfg_target`

## Requirements
- R1: While reset (`rst_n` low) is applied, `ctl_oe` and `ad_oe` are low and `devsel_n`, `trdy_n` and `stop_n` are high. Every register in the bank reads back as zero after reset.
- R2: A transaction is claimed when all of the following hold in the address phase: `idsel` is high, `cbe_n` is 4'b1010 (read) or 4'b1011 (write), and the register index `ad_in[7:2]` is below `NREG`. In the clock after the address phase, `devsel_n` is low, `ctl_oe` is high and `trdy_n` is still high (one fixed wait). `trdy_n` goes low in the clock after that.
- R3: A transaction is never claimed if `idsel` is low, if the command is any other code, or if the index is `NREG` or higher. In that case `devsel_n`, `trdy_n` and `stop_n` stay high, `ctl_oe` stays low, and no register changes. The block decodes again only after `frame_n` and `irdy_n` are both seen high.
- R4: On a write, a data phase completes at an edge where `irdy_n` and `trdy_n` are both low. For each lane i with `cbe_n[i]` low, byte `ad_in[8i+7:8i]` is stored into byte i of the current register. Lanes whose enable is high keep their old value.
- R5: An edge where `irdy_n` is high is a wait. Nothing is written and the current index does not advance.
- R6: On a read, `ad_oe` is high only while `trdy_n` is low. `ad_out` then carries the register at the current index.
- R7: In a burst, the index advances by one after each completed phase. A phase that completes with `frame_n` high is the final phase.
- R8: In the clock after the final phase completes, `devsel_n`, `trdy_n` and `stop_n` are high, `ctl_oe` is still high and `ad_oe` is low. One clock later `ctl_oe` is low.
- R9: The phase at index `NREG-1` is presented with `stop_n` low together with `trdy_n` low, and only that phase is. If that phase completes while `frame_n` is still low, the next clock has `trdy_n` high while `stop_n` and `devsel_n` stay low. These hold until `frame_n` is seen high, and the release then follows R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every input sampled and every output changed on its rising edge |
| rst_n | input | 1 | Active-low reset |
| ad_in | input | 32 | Address/data lines as seen by the target |
| ad_out | output | 32 | Read data driven onto the address/data lines |
| ad_oe | output | 1 | Enable for driving `ad_out` |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| frame_n | input | 1 | Cycle frame from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration chip select |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request, active low |
| ctl_oe | output | 1 | Enable for driving `devsel_n`, `trdy_n` and `stop_n` |

## Verification
A wrong sequencer state is visible on the control lines within one clock. Examples are a missing wait before the first target-ready, a release that skips the turnaround clock, or a stop that misses the last register. Such an error shows as a `devsel_n`, `trdy_n`, `stop_n` or `ctl_oe` value that differs from the fixed cycle count after the address phase or the final phase. A wrong index or a wrong byte-lane merge stays hidden until that register is read. The bench therefore reads back after each write, so a corrupted lane or an extra write shows on `ad_out` within the next transaction. A wait cycle that advances the index shows in the same burst as read data belonging to the next register.

// File: rtl/cfg_target_pkg.sv
package cfg_target_pkg;

  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
  localparam int         IDX_W      = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_WAIT,
    ST_DATA,
    ST_HOLD,
    ST_TURN
  } seq_state_t;

  function automatic logic is_cfg_cmd(input logic [3:0] cmd);
    return (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
  endfunction

  function automatic logic idx_in_bank(input logic [IDX_W-1:0] idx, input int nreg);
    return int'(idx) < nreg;
  endfunction

  function automatic logic idx_is_last(input logic [IDX_W-1:0] idx, input int nreg);
    return int'(idx) == nreg - 1;
  endfunction

  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] idx);
    return idx + IDX_W'(1);
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be_n);
    logic [31:0] res;
    res = old_w;
    for (int ln = 0; ln < 4; ln++) begin
      if (!be_n[ln]) res[ln*8 +: 8] = new_w[ln*8 +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_target_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic [IDX_W-1:0] addr_idx,
  input  logic [3:0]       cmd,
  input  logic             sel,
  output logic             hit,
  output logic             hit_wr,
  output logic [IDX_W-1:0] hit_idx
);

  always_comb begin
    hit     = sel && is_cfg_cmd(cmd) && idx_in_bank(addr_idx, NREG);
    hit_wr  = (cmd == CMD_CFG_WR);
    hit_idx = addr_idx;
  end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_target_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wr_data,
  input  logic [3:0]       wr_be_n,
  output logic [31:0]      rd_data
);

  logic [31:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < NREG; r++) begin
        if (int'(idx) == r) regs[r] <= lane_merge(regs[r], wr_data, wr_be_n);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NREG; r++) begin
      if (int'(idx) == r) rd_data = regs[r];
    end
  end

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_target_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             hit,
  input  logic             hit_wr,
  input  logic [IDX_W-1:0] hit_idx,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             stop_n,
  output logic             ctl_oe,
  output logic             ad_oe,
  output logic [IDX_W-1:0] cur_idx,
  output logic             wr_en,
  output logic             phase_done,
  output logic             addr_skip
);

  seq_state_t state;
  logic       is_wr;
  logic       addr_start;
  logic [IDX_W-1:0] idx_nxt;

  always_comb begin
    addr_start = (state == ST_IDLE) && !frame_n;
    addr_skip  = addr_start && !hit;
    phase_done = (state == ST_DATA) && !irdy_n && !trdy_n;
    wr_en      = phase_done && is_wr;
    idx_nxt    = idx_step(cur_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      ctl_oe   <= 1'b0;
      ad_oe    <= 1'b0;
      cur_idx  <= '0;
      is_wr    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!frame_n) begin
            if (hit) begin
              state    <= ST_WAIT;
              devsel_n <= 1'b0;
              ctl_oe   <= 1'b1;
              cur_idx  <= hit_idx;
              is_wr    <= hit_wr;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_SKIP: begin
          if (frame_n && irdy_n) state <= ST_IDLE;
        end
        ST_WAIT: begin
          trdy_n <= 1'b0;
          stop_n <= !idx_is_last(cur_idx, NREG);
          ad_oe  <= !is_wr;
          state  <= ST_DATA;
        end
        ST_DATA: begin
          if (phase_done) begin
            if (frame_n) begin
              devsel_n <= 1'b1;
              trdy_n   <= 1'b1;
              stop_n   <= 1'b1;
              ad_oe    <= 1'b0;
              state    <= ST_TURN;
            end else if (!stop_n) begin
              trdy_n <= 1'b1;
              ad_oe  <= 1'b0;
              state  <= ST_HOLD;
            end else begin
              cur_idx <= idx_nxt;
              stop_n  <= !idx_is_last(idx_nxt, NREG);
            end
          end
        end
        ST_HOLD: begin
          if (frame_n) begin
            devsel_n <= 1'b1;
            stop_n   <= 1'b1;
            state    <= ST_TURN;
          end
        end
        ST_TURN: begin
          ctl_oe <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_target.sv
module cfg_target
  import cfg_target_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  input  logic [3:0]  cbe_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n,
  output logic        ctl_oe
);

  logic             hit;
  logic             hit_wr;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] cur_idx;
  logic             wr_en;
  logic             phase_done;
  logic             addr_skip;
  logic [31:0]      rd_data;

  cfg_decode #(.NREG(NREG)) u_dec (
    .addr_idx (ad_in[7:2]),
    .cmd      (cbe_n),
    .sel      (idsel),
    .hit      (hit),
    .hit_wr   (hit_wr),
    .hit_idx  (hit_idx)
  );

  cfg_seq #(.NREG(NREG)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .hit        (hit),
    .hit_wr     (hit_wr),
    .hit_idx    (hit_idx),
    .devsel_n   (devsel_n),
    .trdy_n     (trdy_n),
    .stop_n     (stop_n),
    .ctl_oe     (ctl_oe),
    .ad_oe      (ad_oe),
    .cur_idx    (cur_idx),
    .wr_en      (wr_en),
    .phase_done (phase_done),
    .addr_skip  (addr_skip)
  );

  cfg_regbank #(.NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .idx     (cur_idx),
    .wr_data (ad_in),
    .wr_be_n (cbe_n),
    .rd_data (rd_data)
  );

  assign ad_out = ad_oe ? rd_data : '0;

endmodule

// File: rtl/cfg_target_chk.sv
module cfg_target_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_n,
  input logic devsel_n,
  input logic trdy_n,
  input logic stop_n,
  input logic ctl_oe,
  input logic ad_oe,
  input logic phase_done,
  input logic addr_skip
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!ctl_oe && !ad_oe && devsel_n && trdy_n && stop_n));

  a_r2_wait_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> trdy_n);

  a_r2_ready_next: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |=> !trdy_n);

  a_r3_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    addr_skip |=> (devsel_n && !ctl_oe));

  a_r6_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!trdy_n && ctl_oe));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_done && frame_n) |=> (devsel_n && trdy_n && stop_n && ctl_oe && !ad_oe));

  a_r8_float: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_done && frame_n) |=> ##1 !ctl_oe);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_done && !stop_n && !frame_n) |=> (trdy_n && !stop_n && !devsel_n));

endmodule

bind cfg_target cfg_target_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n    (frame_n),
  .devsel_n   (devsel_n),
  .trdy_n     (trdy_n),
  .stop_n     (stop_n),
  .ctl_oe     (ctl_oe),
  .ad_oe      (ad_oe),
  .phase_done (phase_done),
  .addr_skip  (addr_skip)
);

// File: tb/cfg_target_test.sv
module cfg_target_test;

  localparam int NR = 8;
  localparam logic [3:0] RD = 4'b1010;
  localparam logic [3:0] WR = 4'b1011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic        ad_oe;
  logic [3:0]  cbe_n = '0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic        idsel = 1'b0;
  logic        devsel_n, trdy_n, stop_n, ctl_oe;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] mdl [NR];

  always #10 clk = ~clk;

  cfg_target #(.NREG(NR)) uut (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .cbe_n(cbe_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge_ref(input logic [31:0] old_w, input logic [31:0] d,
                                            input logic [3:0] be);
    logic [31:0] mask;
    mask = {{8{~be[3]}}, {8{~be[2]}}, {8{~be[1]}}, {8{~be[0]}}};
    return (old_w & ~mask) | (d & mask);
  endfunction

  function automatic logic [31:0] pat(input logic [31:0] seed, input int p);
    return seed + 32'(p) * 32'h0102_0304;
  endfunction

  task automatic xfer(input logic [3:0] cmd, input bit sel, input int start, input int nph,
                      input int wait_ph, input logic [3:0] be, input logic [31:0] seed);
    bit claim, wr, fin, stp, waited;
    int p, guard;
    claim = sel && (cmd == RD || cmd == WR) && start < NR;
    wr = (cmd == WR);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = cmd; idsel = sel;
    ad_in = {24'h0, 6'(start), 2'b00};
    @(negedge clk);
    idsel = 1'b0;
    if (!claim) begin
      chk(devsel_n && !ctl_oe, "R3 not claimed", {30'b0, ctl_oe, devsel_n}, 32'h1);
      irdy_n = 1'b0; frame_n = 1'b1; cbe_n = be; ad_in = pat(seed, 0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(devsel_n && trdy_n && stop_n && !ctl_oe, "R3 stays quiet",
            {28'b0, ctl_oe, devsel_n, trdy_n, stop_n}, 32'h7);
        irdy_n = 1'b1;
      end
      return;
    end
    chk(!devsel_n && trdy_n && ctl_oe, "R2 claim with one wait",
        {29'b0, ctl_oe, devsel_n, trdy_n}, 32'h5);
    p = 0; fin = 0; stp = 0; waited = 0; guard = 0;
    while (!fin && !stp && guard < 50) begin
      guard++;
      if (p == wait_ph && !waited) begin
        irdy_n = 1'b1; waited = 1;
      end else begin
        irdy_n = 1'b0;
      end
      frame_n = (!irdy_n && p == nph - 1);
      cbe_n = be;
      ad_in = pat(seed, p);
      if (!irdy_n && !trdy_n) begin
        int ix;
        ix = start + p;
        chk(stop_n == !(ix == NR - 1), "R9 stop only at last register", {31'b0, stop_n},
            {31'b0, !(ix == NR - 1)});
        if (wr) begin
          mdl[ix] = merge_ref(mdl[ix], ad_in, be);
        end else begin
          chk(ad_oe, "R6 read enable", {31'b0, ad_oe}, 32'h1);
          chk(ad_out == mdl[ix], "R4/R5/R6/R7 read data", ad_out, mdl[ix]);
        end
        fin = frame_n;
        stp = !frame_n && !stop_n;
        p++;
      end
      @(negedge clk);
    end
    chk(guard < 50, "R7 burst ends", 32'(guard), 32'd50);
    if (stp) begin
      chk(trdy_n && !stop_n && !devsel_n, "R9 disconnect hold",
          {29'b0, devsel_n, trdy_n, stop_n}, 32'h2);
      frame_n = 1'b1; irdy_n = 1'b1;
      @(negedge clk);
    end
    chk(devsel_n && trdy_n && stop_n && ctl_oe && !ad_oe, "R8 release with drive",
        {27'b0, ad_oe, ctl_oe, devsel_n, trdy_n, stop_n}, 32'hF);
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    chk(!ctl_oe, "R8 float after turnaround", {31'b0, ctl_oe}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    repeat (2) @(negedge clk);
    chk(!ctl_oe && !ad_oe && devsel_n && trdy_n && stop_n, "R1 reset outputs",
        {27'b0, ad_oe, ctl_oe, devsel_n, trdy_n, stop_n}, 32'h7);
    rst_n = 1'b1;
    // R1: bank reads zero
    xfer(RD, 1, 0, NR, -1, 4'h0, 32'h0);
    for (int i = 0; i < NR; i++) begin
      xfer(WR, 1, i, 1, -1, 4'h0, 32'hA500_0000 + 32'(i) * 32'h0001_1111);
      xfer(RD, 1, i, 1, -1, 4'h0, 32'h0);
    end
    // R4: every byte-enable pattern on one register
    for (int b = 0; b < 16; b++) begin
      xfer(WR, 1, 2, 1, -1, 4'(b), 32'h1357_9BDF ^ (32'(b) * 32'h1111_1111));
      xfer(RD, 1, 2, 1, -1, 4'h0, 32'h0);
    end
    // R5 and R7: bursts with wait cycles
    xfer(WR, 1, 0, NR, 3, 4'h0, 32'h0F1E_2D3C);
    xfer(RD, 1, 0, NR, 5, 4'h0, 32'h0);
    // R9: disconnect past the last register
    xfer(WR, 1, 5, 6, 1, 4'b0101, 32'hDEAD_BEEF);
    xfer(RD, 1, 6, 4, -1, 4'h0, 32'h0);
    // R3: ignored accesses
    xfer(WR, 0, 1, 1, -1, 4'h0, 32'hFFFF_FFFF);
    xfer(4'b0111, 1, 1, 1, -1, 4'h0, 32'hFFFF_FFFF);
    xfer(WR, 1, 40, 1, -1, 4'h0, 32'hFFFF_FFFF);
    xfer(RD, 1, 0, NR, 2, 4'h0, 32'h0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule